// File: doc/BRIEF.md
# Byte-Framed Serial Control Port with Channel Broadcast

This block is the control port of a four-channel line device. A host talks to it over three wires: a data clock, an active-low select, and one data line. The data line is split here into an input, an output and an output-enable, so the pad ring can build the shared bidirectional pin. Each byte is framed by its own select pulse, and bits travel most significant first. The first byte of a transaction is a command. Bit 0 of the command gives the direction: an even code writes and an odd code reads. The command is followed by exactly one data byte, sent by the host for a write and by the block for a read. The byte after that is decoded as a new command.

The block holds a channel-enable register and two 8-bit configuration registers per channel, called A and B. A write to A or B lands in every enabled channel in the same clock cycle, so one transaction can configure several channels at once. A read of A, B or the line inputs is served by the lowest-numbered enabled channel. A global revision code can also be read.

All pins are sampled in the system clock domain through a synchronizer. Inside the block, bytes pass between the shifter and the decoder as single-cycle pulses. This path has no back-pressure, because the select off-time between bytes gives the decoder many cycles of slack.

Top module: `sci_port`

## Requirements
- R1: After reset, every channel's A and B registers are 00h, the enable register is 0, and the output enable is low.
- R2: Bits are captured on data-clock rising edges, MSB first. Command 44h followed by a data byte writes register A. Command 46h followed by a data byte writes register B. Bit k of the enable register (k = 0..3) controls channel k+1. Channel k+1's A and B registers appear on `ch_a`/`ch_b` bits [8k+7:8k].
- R3: A write to A or B updates every enabled channel in the same clock cycle.
- R4: Reads 45h (register A) and 47h (register B) return the value of the lowest-numbered enabled channel. With no channel enabled, they return 00h.
- R5: Command 4Ah writes the enable register from data bits [3:0]; bits [7:4] are dropped. Command 4Bh returns the enable register in bits [3:0], with zeros above.
- R6: Command 53h returns the lowest-numbered enabled channel's line inputs (`line_in` bits [5k+4:5k] for channel k+1), zero-extended. It returns 00h with no channel enabled. Command 73h returns the revision parameter (default 2Ah).
- R7: The output enable is high only while select is low during a read data byte. The output changes only after a falling data-clock edge, and the first bit is presented when select falls.
- R8: If select rises before eight rising edges have been counted, the partial byte is discarded and the command/data state does not advance.
- R9: After the one data byte of a command, the next byte is decoded as a command.
- R10: An undefined even opcode is ignored, and the next byte is decoded as a command. An undefined odd opcode, including the odd code of a writable-only pair, is followed by one read byte of 00h.
- R11: Registers of channels whose enable bit is clear never change on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial data clock (idle low) |
| cs_n | input | 1 | Active-low byte select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the shared data pin |
| line_in | input | NCH*LINE_W | Per-channel line input states |
| ch_a | output | NCH*8 | Register A of each channel |
| ch_b | output | NCH*8 | Register B of each channel |

## Verification
The bench builds the block with its defaults: four channels, 5-bit line inputs, revision 2Ah and a two-stage synchronizer. With four channels, the bench can set enable patterns in which the lowest enabled channel is 1, 2 or 3, patterns with gaps, and the empty pattern, so both the broadcast rule and the priority rule are exercised in several shapes. Running the data clock at eight system cycles per period leaves room for the synchronizer latency, so aborted bytes can be cut off cleanly in both the command phase and the data phase.

// File: rtl/sci_pkg.sv
package sci_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD} phase_e;
  typedef enum logic [2:0] {TGT_NONE, TGT_A, TGT_B, TGT_EN, TGT_LINE, TGT_REV} tgt_e;

  // opcode pairs, bit 0 cleared; bit 0 of the received code is the direction
  localparam logic [7:0] OPP_A    = 8'h44;
  localparam logic [7:0] OPP_B    = 8'h46;
  localparam logic [7:0] OPP_EN   = 8'h4A;
  localparam logic [7:0] OPP_LINE = 8'h52;
  localparam logic [7:0] OPP_REV  = 8'h72;
endpackage

// File: rtl/sci_shifter.sv
module sci_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdi,
  input  logic [7:0] tx_byte,
  input  logic       tx_pending,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       sdo,
  output logic       sdo_oe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] cs_pipe, sclk_pipe, sdi_pipe;
  logic cs_s, sclk_s, sdi_s, sclk_d, cs_d;
  logic sclk_rise, sclk_fall, cs_fall;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic tx_act;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe <= '1; sclk_pipe <= '0; sdi_pipe <= '0;
        end else begin
          cs_pipe <= cs_n; sclk_pipe <= sclk; sdi_pipe <= sdi;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_pipe <= '1; sclk_pipe <= '0; sdi_pipe <= '0;
        end else begin
          cs_pipe   <= {cs_pipe[TOP-1:0], cs_n};
          sclk_pipe <= {sclk_pipe[TOP-1:0], sclk};
          sdi_pipe  <= {sdi_pipe[TOP-1:0], sdi};
        end
      end
    end
  endgenerate

  assign cs_s   = cs_pipe[TOP];
  assign sclk_s = sclk_pipe[TOP];
  assign sdi_s  = sdi_pipe[TOP];

  assign sclk_rise = !cs_s && sclk_s && !sclk_d;
  assign sclk_fall = !cs_s && !sclk_s && sclk_d;
  assign cs_fall   = cs_d && !cs_s;

  // receive path: count to eight, then hold until select rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cs_d <= 1'b1;
      bit_cnt <= '0; rx_sh <= '0; rx_byte <= '0; rx_valid <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      cs_d     <= cs_s;
      rx_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise && bit_cnt < 4'd8) begin
        rx_sh   <= {rx_sh[6:0], sdi_s};
        bit_cnt <= bit_cnt + 4'd1;
        if (bit_cnt == 4'd7) begin
          rx_byte  <= {rx_sh[6:0], sdi_s};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // transmit path: load at select fall, advance on each falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; tx_act <= 1'b0;
    end else if (cs_s) begin
      tx_act <= 1'b0;
    end else if (cs_fall) begin
      tx_sh  <= tx_byte;
      tx_act <= tx_pending;
    end else if (sclk_fall && tx_act) begin
      tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign sdo    = tx_sh[7];
  assign sdo_oe = tx_act && !cs_s;
endmodule

// File: rtl/sci_ctrl.sv
module sci_ctrl
  import sci_pkg::*;
#(
  parameter int          NCH    = 4,
  parameter int          LINE_W = 5,
  parameter logic [7:0]  REV    = 8'h2A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            rx_byte,
  input  logic                  rx_valid,
  input  logic [NCH*LINE_W-1:0] line_in,
  input  logic [NCH*8-1:0]      reg_a,
  input  logic [NCH*8-1:0]      reg_b,
  output logic [NCH-1:0]        en_q,
  output logic                  wr_a,
  output logic                  wr_b,
  output logic [7:0]            wr_data,
  output logic [7:0]            tx_byte,
  output logic                  tx_pending
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  phase_e phase_q;
  tgt_e   tgt_q, dec_tgt;
  logic   dec_rd;
  logic [CW-1:0] sel;
  logic          found;

  always_comb begin
    dec_rd = rx_byte[0];
    unique case ({rx_byte[7:1], 1'b0})
      OPP_A:    dec_tgt = TGT_A;
      OPP_B:    dec_tgt = TGT_B;
      OPP_EN:   dec_tgt = TGT_EN;
      OPP_LINE: dec_tgt = dec_rd ? TGT_LINE : TGT_NONE;
      OPP_REV:  dec_tgt = dec_rd ? TGT_REV  : TGT_NONE;
      default:  dec_tgt = TGT_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD; tgt_q <= TGT_NONE; en_q <= '0;
    end else if (rx_valid) begin
      unique case (phase_q)
        PH_CMD: begin
          tgt_q <= dec_tgt;
          if (dec_rd)                   phase_q <= PH_RD;
          else if (dec_tgt != TGT_NONE) phase_q <= PH_WR;
        end
        PH_WR: begin
          if (tgt_q == TGT_EN) en_q <= rx_byte[NCH-1:0];
          phase_q <= PH_CMD;
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  assign wr_a    = rx_valid && phase_q == PH_WR && tgt_q == TGT_A;
  assign wr_b    = rx_valid && phase_q == PH_WR && tgt_q == TGT_B;
  assign wr_data = rx_byte;

  // lowest-numbered enabled channel wins
  always_comb begin
    sel = '0; found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (en_q[i]) begin
        sel = CW'(i); found = 1'b1;
      end
    end
  end

  always_comb begin
    tx_byte = 8'h00;
    unique case (tgt_q)
      TGT_A:    if (found) tx_byte = reg_a[sel*8 +: 8];
      TGT_B:    if (found) tx_byte = reg_b[sel*8 +: 8];
      TGT_EN:   tx_byte = 8'(en_q);
      TGT_LINE: if (found) tx_byte = 8'(line_in[sel*LINE_W +: LINE_W]);
      TGT_REV:  tx_byte = REV;
      default:  tx_byte = 8'h00;
    endcase
  end

  assign tx_pending = (phase_q == PH_RD);
endmodule

// File: rtl/sci_chregs.sv
module sci_chregs #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   en,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [7:0]       wr_data,
  output logic [NCH*8-1:0] reg_a,
  output logic [NCH*8-1:0] reg_b
);
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_a[c*8 +: 8] <= '0;
          reg_b[c*8 +: 8] <= '0;
        end else begin
          if (wr_a && en[c]) reg_a[c*8 +: 8] <= wr_data;
          if (wr_b && en[c]) reg_b[c*8 +: 8] <= wr_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sci_port.sv
module sci_port #(
  parameter int         NCH         = 4,
  parameter int         LINE_W      = 5,
  parameter logic [7:0] REV         = 8'h2A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic [NCH*LINE_W-1:0] line_in,
  output logic [NCH*8-1:0]      ch_a,
  output logic [NCH*8-1:0]      ch_b
);
  logic [7:0]     rx_byte, tx_byte, wr_data;
  logic           rx_valid, tx_pending, wr_a, wr_b;
  logic [NCH-1:0] en_q;

  sci_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .tx_byte(tx_byte), .tx_pending(tx_pending),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  sci_ctrl #(.NCH(NCH), .LINE_W(LINE_W), .REV(REV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .line_in(line_in), .reg_a(ch_a), .reg_b(ch_b), .en_q(en_q),
    .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
    .tx_byte(tx_byte), .tx_pending(tx_pending)
  );

  sci_chregs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en_q), .wr_a(wr_a), .wr_b(wr_b),
    .wr_data(wr_data), .reg_a(ch_a), .reg_b(ch_b)
  );
endmodule

// File: rtl/sci_port_chk.sv
module sci_port_chk
  import sci_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             sclk_fall,
  input logic [3:0]       bit_cnt,
  input logic             rx_valid,
  input phase_e           phase,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [NCH-1:0]   en,
  input logic [NCH*8-1:0] reg_a,
  input logic [NCH*8-1:0] reg_b
);
  // R7: no drive while deselected
  p_oe_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !sdo_oe);

  // R7: output only moves after a falling data-clock edge
  p_sdo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo));

  // R8: deselect clears any partial byte
  p_partial_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == 4'd0));

  // R9: one data byte, then back to command decode
  p_one_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && phase != PH_CMD) |=> (phase == PH_CMD));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_keep
      // R11: disabled channels keep their contents
      p_keep_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en[c] |=> $stable(reg_a[c*8 +: 8]));
      p_keep_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en[c] |=> $stable(reg_b[c*8 +: 8]));
    end
  endgenerate
endmodule

bind sci_port sci_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(u_shift.cs_s), .sclk_fall(u_shift.sclk_fall),
  .bit_cnt(u_shift.bit_cnt), .rx_valid(rx_valid), .phase(u_ctrl.phase_q),
  .sdo(sdo), .sdo_oe(sdo_oe), .en(en_q), .reg_a(ch_a), .reg_b(ch_b)
);

// File: tb/sci_port_bench.sv
module sci_port_bench;
  localparam int NCH = 4;
  localparam int LW  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [NCH*LW-1:0] line_in;
  logic [NCH*8-1:0]  ch_a, ch_b;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_a [NCH];
  logic [7:0] exp_b [NCH];
  logic [NCH-1:0] exp_en;

  always #10 clk = ~clk;

  sci_port u_sci_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .line_in(line_in), .ch_a(ch_a), .ch_b(ch_b)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one select-framed byte; host samples sdo just before each rising edge
  task automatic xfer(input logic [7:0] d, input int nbits,
                      output logic [7:0] got, output logic oe_all, output logic oe_any);
    got = '0; oe_all = 1'b1; oe_any = 1'b0;
    wait_clk(1); cs_n = 1'b0; wait_clk(4);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = d[i]; wait_clk(4);
      got = {got[6:0], sdo};
      oe_all &= sdo_oe; oe_any |= sdo_oe;
      sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(4); cs_n = 1'b1; wait_clk(6);
  endtask

  task automatic wr_cmd(input logic [7:0] op, input logic [7:0] d);
    logic [7:0] g; logic oa, on;
    xfer(op, 8, g, oa, on);
    chk("R7 no drive on command", {31'd0, on}, 32'd0);
    xfer(d, 8, g, oa, on);
    chk("R7 no drive on write data", {31'd0, on}, 32'd0);
    if (op == 8'h4A) exp_en = d[NCH-1:0];
    for (int c = 0; c < NCH; c++) if (exp_en[c]) begin
      if (op == 8'h44) exp_a[c] = d;
      if (op == 8'h46) exp_b[c] = d;
    end
  endtask

  task automatic rd_cmd(input string tag, input logic [7:0] op, input logic [7:0] exp);
    logic [7:0] g; logic oa, on;
    xfer(op, 8, g, oa, on);
    xfer(8'h00, 8, g, oa, on);
    chk({tag, " data"}, {24'd0, g}, {24'd0, exp});
    chk("R7 drive during read byte", {31'd0, oa}, 32'd1);
    chk("R7 released after deselect", {31'd0, sdo_oe}, 32'd0);
  endtask

  task automatic chk_regs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " A"}, {24'd0, ch_a[c*8 +: 8]}, {24'd0, exp_a[c]});
      chk({tag, " B"}, {24'd0, ch_b[c*8 +: 8]}, {24'd0, exp_b[c]});
    end
  endtask

  task automatic t_reset;
    chk_regs("R1 reset regs");
    chk("R1 oe low", {31'd0, sdo_oe}, 32'd0);
    rd_cmd("R1 R5 enable after reset", 8'h4B, 8'h00);
  endtask

  task automatic t_enable;
    wr_cmd(8'h4A, 8'hF5);
    rd_cmd("R5 enable upper bits dropped", 8'h4B, 8'h05);
  endtask

  task automatic t_broadcast;
    wr_cmd(8'h44, 8'hA5);           // channels 1 and 3
    chk_regs("R2 R3 R11 broadcast A");
    wr_cmd(8'h4A, 8'h0A);
    wr_cmd(8'h46, 8'h3C);           // channels 2 and 4
    chk_regs("R3 R11 broadcast B");
    wr_cmd(8'h4A, 8'h02);
    wr_cmd(8'h44, 8'h5E);           // channel 2 only
    chk_regs("R2 R11 single A");
  endtask

  task automatic t_read_first;
    wr_cmd(8'h4A, 8'h0C);
    rd_cmd("R4 first of 3,4 reg A", 8'h45, exp_a[2]);
    wr_cmd(8'h4A, 8'h06);
    rd_cmd("R4 first of 2,3 reg B", 8'h47, exp_b[1]);
    wr_cmd(8'h4A, 8'h0F);
    rd_cmd("R4 first of all reg A", 8'h45, exp_a[0]);
    wr_cmd(8'h4A, 8'h00);
    rd_cmd("R4 none enabled", 8'h45, 8'h00);
  endtask

  task automatic t_status;
    wr_cmd(8'h4A, 8'h04);
    rd_cmd("R6 line ch3", 8'h53, 8'h1E);
    wr_cmd(8'h4A, 8'h09);
    rd_cmd("R6 line ch1", 8'h53, 8'h11);
    wr_cmd(8'h4A, 8'h00);
    rd_cmd("R6 line none", 8'h53, 8'h00);
    rd_cmd("R6 revision", 8'h73, 8'h2A);
  endtask

  task automatic t_partial;
    logic [7:0] g; logic oa, on;
    xfer(8'h44, 5, g, oa, on);      // aborted command
    wr_cmd(8'h4A, 8'h03);
    rd_cmd("R8 R9 after aborted command", 8'h4B, 8'h03);
    xfer(8'h44, 8, g, oa, on);
    xfer(8'hFF, 3, g, oa, on);      // aborted data byte
    chk_regs("R8 aborted data no write");
    xfer(8'h11, 8, g, oa, on);
    exp_a[0] = 8'h11; exp_a[1] = 8'h11;
    chk_regs("R8 data after abort");
  endtask

  task automatic t_undef;
    logic [7:0] g; logic oa, on;
    xfer(8'h60, 8, g, oa, on);      // undefined even: ignored
    rd_cmd("R10 byte after undefined even is command", 8'h4B, 8'h03);
    xfer(8'h52, 8, g, oa, on);      // write code of read-only pair
    rd_cmd("R10 byte after 52h is command", 8'h4B, 8'h03);
    rd_cmd("R10 undefined odd returns zero", 8'h61, 8'h00);
    rd_cmd("R9 R10 command after undefined read", 8'h4B, 8'h03);
    chk_regs("R10 no register change");
  endtask

  initial begin
    line_in = {5'h0A, 5'h1E, 5'h07, 5'h11};
    exp_en = '0;
    for (int c = 0; c < NCH; c++) begin exp_a[c] = '0; exp_b[c] = '0; end
    wait_clk(5); rst_n = 1'b1; wait_clk(3);
    t_reset;
    t_enable;
    t_broadcast;
    t_read_first;
    t_status;
    t_partial;
    t_undef;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule